// File: doc/BRIEF.md
# Saturating Up/Down Counter Deglitch Filter

This block cleans up a noisy serial receive line before it reaches a receiver. The raw line first passes through a two-flop synchroniser. A small saturating counter then integrates the synchronised level. The counter moves one step per filter tick: it moves up while the line is high and down while it is low. The filtered output only changes when the counter is already at an end point and the line still pushes past it. A glitch therefore has to last a full count of filter ticks before it can change the output. The rejection is the same for high-going and low-going pulses.

Filter ticks come from the system clock through a clock-enable prescaler. There is no derived clock. A two-bit select picks the divide ratio. The filter delay is fixed by the counter width and the divide ratio. A pulse that reverses before reaching an end point leaves the counter where it stopped, and the counter turns around from that value.

Top module: `updown_deglitch`

## Requirements
- R1: After reset the filtered output is high and the counter holds its maximum value 0xF, matching an idle-high line.
- R2: The raw input passes through two synchroniser flops. With select 0 (divide-by-1), a steady low on the raw line makes the filtered output go low on the 18th rising clock edge after the raw change.
- R3: A low pulse lasting fewer than 16 filter ticks does not change a high filtered output. At divide-by-1 this covers a 15-cycle pulse.
- R4: A low level lasting 16 filter ticks drives the filtered output low. The output falls only on a tick where the counter is already 0x0 and the line is low.
- R5: With the output low, a high pulse lasting fewer than 16 ticks is rejected. A high level lasting 16 ticks drives the output high, and it rises only on a tick where the counter is already 0xF and the line is high.
- R6: The counter saturates at 0x0 and 0xF and never wraps. Holding a level for any time beyond 16 ticks does not shorten the rejection window for the opposite level.
- R7: When the line reverses before an end point is reached, the counter turns around from its current value and changes by at most one per tick. Low for 10 ticks, then high for 5, then low for 11 ticks drives the output low.
- R8: The select encodes the divide ratio: 0 means divide-by-1, 1 means divide-by-2, 2 means divide-by-4 and 3 means divide-by-8. The counter and output change only on tick cycles. At divide N, a low pulse of 15·N cycles is rejected and one of 17·N cycles drives the output low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_sel | input | 2 | Prescaler select: 0 → /1, 1 → /2, 2 → /4, 3 → /8 |
| raw_in | input | 1 | Unfiltered serial line, may be asynchronous |
| filt_out | output | 1 | Deglitched line |

## Verification
The assertions assume that the divide select is held steady while the filter is running. Under that assumption, the tick spacing is constant between resets. They also assume that reset is asserted across at least one clock edge at start-up, so every property sees register values from reset onward. The bench changes the select only while reset is asserted. It drives the raw line just after falling edges, so every level it applies is a clean whole number of clock cycles.

// File: rtl/updown_deglitch.sv
module updown_deglitch #(
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2,
  parameter int SEL_W       = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] div_sel,
  input  logic             raw_in,
  output logic             filt_out
);
  localparam int PRE_W = (1 << SEL_W) - 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_MIN = '0;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [PRE_W-1:0]       pre_q;
  logic [PRE_W-1:0]       pre_mask;
  logic [PRE_W:0]         sel_bit;
  logic [CNT_W-1:0]       cnt_q;
  logic                   line;
  logic                   tick;

  assign sel_bit  = (PRE_W+1)'(1) << div_sel;
  assign pre_mask = PRE_W'(sel_bit - 1'b1);
  assign tick     = (pre_q & pre_mask) == pre_mask;
  assign line     = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_in};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_q    <= CNT_MAX;
      filt_out <= 1'b1;
    end else if (tick) begin
      if (line) begin
        if (cnt_q == CNT_MAX) filt_out <= 1'b1;
        else                  cnt_q    <= cnt_q + 1'b1;
      end else begin
        if (cnt_q == CNT_MIN) filt_out <= 1'b0;
        else                  cnt_q    <= cnt_q - 1'b1;
      end
    end

  p_reset_state_r1: assert property (@(posedge clk)
    !rst_n |=> (filt_out && cnt_q == CNT_MAX));

  p_fall_at_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(filt_out) |-> ($past(cnt_q) == CNT_MIN && !$past(line)));

  p_rise_at_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(filt_out) |-> ($past(cnt_q) == CNT_MAX && $past(line)));

  p_no_wrap_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt_q) == CNT_MAX && $past(line)) |-> cnt_q == CNT_MAX);

  p_no_wrap_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt_q) == CNT_MIN && !$past(line)) |-> cnt_q == CNT_MIN);

  p_single_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == $past(cnt_q) || cnt_q == CNT_W'($past(cnt_q) + 1'b1) ||
     cnt_q == CNT_W'($past(cnt_q) - 1'b1)));

  p_idle_between_ticks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick) |-> ($stable(cnt_q) && $stable(filt_out)));
endmodule

// File: tb/updown_deglitch_test.sv
module updown_deglitch_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] div_sel = 2'd0;
  logic       raw_in = 1'b1;
  logic       filt_out;
  int         n_vec = 0;
  int         n_bad = 0;

  updown_deglitch uut (
    .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .raw_in(raw_in), .filt_out(filt_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input int act, input int exp, input string req);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] sel);
    @(negedge clk);
    rst_n = 1'b0; raw_in = 1'b1; div_sel = sel;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic hold(input logic lvl, input int cycles);
    @(negedge clk);
    raw_in = lvl;
    repeat (cycles - 1) @(negedge clk);
  endtask

  task automatic t_reset;
    do_reset(2'd0);
    chk(filt_out, 1, "R1 output after reset");
    hold(1'b1, 40);
    chk(filt_out, 1, "R1 idle high stays high");
  endtask

  task automatic t_latency;
    int k;
    do_reset(2'd0);
    @(negedge clk);
    raw_in = 1'b0;
    k = 0;
    while (filt_out && k < 40) begin
      @(posedge clk); @(negedge clk);
      k++;
    end
    chk(k, 18, "R2 edges until output falls");
  endtask

  task automatic t_low_pulses;
    do_reset(2'd0);
    hold(1'b0, 15); hold(1'b1, 5);
    chk(filt_out, 1, "R3 15-tick low pulse rejected");
    do_reset(2'd0);
    hold(1'b0, 16); hold(1'b1, 5);
    chk(filt_out, 0, "R4 16-tick low drives output low");
  endtask

  task automatic t_high_pulses;
    do_reset(2'd0);
    hold(1'b0, 20);
    chk(filt_out, 0, "R5 setup output low");
    hold(1'b1, 15); hold(1'b0, 5);
    chk(filt_out, 0, "R5 15-tick high pulse rejected");
    do_reset(2'd0);
    hold(1'b0, 20); hold(1'b1, 16); hold(1'b0, 5);
    chk(filt_out, 1, "R5 16-tick high drives output high");
  endtask

  task automatic t_saturate;
    do_reset(2'd0);
    hold(1'b1, 60); hold(1'b0, 15); hold(1'b1, 5);
    chk(filt_out, 1, "R6 no wrap at top");
    do_reset(2'd0);
    hold(1'b0, 60); hold(1'b1, 15); hold(1'b0, 5);
    chk(filt_out, 0, "R6 no wrap at floor");
  endtask

  task automatic t_reverse;
    do_reset(2'd0);
    hold(1'b0, 10); hold(1'b1, 5); hold(1'b0, 10); hold(1'b1, 3);
    chk(filt_out, 1, "R7 ten low after reversal not enough");
    do_reset(2'd0);
    hold(1'b0, 10); hold(1'b1, 5); hold(1'b0, 11); hold(1'b1, 3);
    chk(filt_out, 0, "R7 reversal continues from current count");
  endtask

  task automatic t_prescale(input logic [1:0] sel);
    int n;
    n = 1 << sel;
    do_reset(sel);
    hold(1'b0, 15 * n); hold(1'b1, 3 * n + 3);
    chk(filt_out, 1, $sformatf("R8 div %0d short pulse rejected", n));
    do_reset(sel);
    hold(1'b0, 17 * n); hold(1'b1, 3 * n + 3);
    chk(filt_out, 0, $sformatf("R8 div %0d long pulse accepted", n));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_latency();
    t_low_pulses();
    t_high_pulses();
    t_saturate();
    t_reverse();
    for (int s = 0; s < 4; s++) t_prescale(2'(s));
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule